// File: doc/BRIEF.md
# Double-Buffered Serial Word Transmitter

This block turns parallel words into a serial bit stream for the data line of a SPI-style link. A one-cycle load strobe with a data word starts a transfer. The word is shifted out most significant bit first. Each bit stays on the output for one clock cycle. A busy flag is high for as long as bits are being shifted.

Behind the shift register sits a holding register for one word. A second word may be strobed in while the first is still shifting. It then follows the last bit of the first word with no idle cycle between them. The ready flag drops only when both the shifter and the holding register are occupied. A strobe that arrives while ready is low is dropped.

The block uses one clock and a synchronous, active-low reset. It does not generate a serial clock, drive a chip select, offer polarity or phase options, or receive data.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `ready_o` is 1, `busy_o` is 0 and `sdo_o` is 0. A reset in the middle of a transfer also returns the block to this state.
- R2: Bits leave on `sdo_o` most significant bit first. Each bit is held for exactly one cycle, so one word occupies WIDTH consecutive cycles.
- R3: A strobe sampled on `load_i` while the block is idle makes `busy_o` high and puts bit WIDTH-1 of the word on `sdo_o` in the very next cycle.
- R4: When nothing is queued, `busy_o` goes low in the cycle after the last bit, and `sdo_o` is 0 while the block is idle.
- R5: While one word is shifting and the holding register is empty, `ready_o` stays 1.
- R6: A strobe accepted while a word is shifting, other than during its last bit, is stored in the holding register. `ready_o` is 0 from the following cycle.
- R7: A queued word's first bit appears in the cycle right after the previous word's last bit. A strobe sampled during the last bit of a word, with the holding register empty, is also sent with no gap.
- R8: `ready_o` returns to 1 in the same cycle that the queued word's first bit appears on `sdo_o`.
- R9: A strobe sampled while `ready_o` is 0 is ignored. Neither the queued word nor the word being shifted changes.
- R10: The word width is the parameter WIDTH, with a default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that offers `data_i` |
| data_i | input | WIDTH | Word to transmit |
| ready_o | output | 1 | High when a strobe will be accepted |
| busy_o | output | 1 | High while bits are being shifted out |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
The main table sends two words back to back. The words are 8'hE2 and 8'h1D, which are bit complements of each other, so a swapped or reordered bit shows up as a wrong level at once. A third strobe (8'hFF) is given while the holding register is full. Any leak from it into the stream breaks the expected 1D pattern, which separates a dropped strobe from an overwrite. A word (8'hA5) is strobed during the last bit of a word with the holding register empty. This tells a gapless direct load apart from one that inserts an idle cycle. Directed runs add a single 8'h80, whose lone leading one exposes off-by-one errors in the bit count. They also add a reset in the middle of a word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned SERTX_DEF_WIDTH = 8;

  function automatic int unsigned cnt_bits(input int unsigned width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
  parameter int unsigned WIDTH = sertx_pkg::SERTX_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             take,
  output logic             full,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_en) begin
      full <= 1'b1;
      word <= wr_word;
    end
  end

  // R9: a full buffer keeps its word until it is taken
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(word)));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned WIDTH = sertx_pkg::SERTX_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_word,
  output logic             sdo,
  output logic             busy,
  output logic             last
);
  localparam int unsigned CW = sertx_pkg::cnt_bits(WIDTH);

  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load_en) begin
      shreg  <= load_word;
      remain <= CW'(WIDTH);
    end else if (remain != '0) begin
      shreg  <= {shreg[WIDTH-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign sdo  = shreg[WIDTH-1];
  assign busy = (remain != '0);
  assign last = (remain == CW'(1));

  // R2: the first bit of a freshly loaded word is its MSB
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sdo == $past(load_word[WIDTH-1])));
  // R4: the line is low whenever no bits are shifting
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && !load_en) |=> (!busy && !sdo));
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int unsigned WIDTH = sertx_pkg::SERTX_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             sdo_o
);
  logic             sh_busy, sh_last, sh_load;
  logic [WIDTH-1:0] sh_word;
  logic             hb_full, hb_wr, hb_take;
  logic [WIDTH-1:0] hb_word;
  logic             free_next;

  // The shifter can take a word at this edge if it is idle or on its last bit
  assign free_next = !sh_busy || sh_last;
  assign hb_take   = free_next && hb_full;
  assign hb_wr     = load_i && !free_next && !hb_full;
  assign sh_load   = hb_take || (free_next && !hb_full && load_i);
  assign sh_word   = hb_take ? hb_word : data_i;

  sertx_shifter #(.WIDTH(WIDTH)) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (sh_load),
    .load_word (sh_word),
    .sdo       (sdo_o),
    .busy      (sh_busy),
    .last      (sh_last)
  );

  sertx_holdreg #(.WIDTH(WIDTH)) holdreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hb_wr),
    .wr_word (data_i),
    .take    (hb_take),
    .full    (hb_full),
    .word    (hb_word)
  );

  assign ready_o = !hb_full;
  assign busy_o  = sh_busy;

  // R3: an idle strobe starts output on the next cycle
  p_start_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && load_i) |=> (busy_o && sdo_o == $past(data_i[WIDTH-1])));
  // R5: nothing can be queued while idle
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ready_o);
  // R6: queueing a word drops ready in the next cycle
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sh_last && ready_o && load_i) |=> !ready_o);
  // R7 and R8: queued word follows with no gap and ready comes back
  p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sh_last && !ready_o) |=> (busy_o && ready_o));
endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 26;

  // Row layout: {load, data[7:0], exp_ready, exp_busy, exp_sdo}
  // The expected bits are what the outputs show before the row's inputs are driven.
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 8'hE2, 3'b100},                         // idle, strobe A (R3)
    {1'b1, 8'h1D, 3'b111},                         // A bit7, queue B (R6)
    {1'b0, 8'h00, 3'b011},                         // ready low
    {1'b1, 8'hFF, 3'b011},                         // strobe ignored (R9)
    {1'b0, 8'h00, 3'b010}, {1'b0, 8'h00, 3'b010}, {1'b0, 8'h00, 3'b010},
    {1'b0, 8'h00, 3'b011}, {1'b0, 8'h00, 3'b010},  // A ends
    {1'b0, 8'h00, 3'b110}, {1'b0, 8'h00, 3'b110},  // B with no gap (R7, R8)
    {1'b0, 8'h00, 3'b110}, {1'b0, 8'h00, 3'b111},
    {1'b0, 8'h00, 3'b111}, {1'b0, 8'h00, 3'b111},
    {1'b0, 8'h00, 3'b110},
    {1'b1, 8'hA5, 3'b111},                         // B last bit, direct load (R7)
    {1'b0, 8'h00, 3'b111}, {1'b0, 8'h00, 3'b110},
    {1'b0, 8'h00, 3'b111}, {1'b0, 8'h00, 3'b110},
    {1'b0, 8'h00, 3'b110}, {1'b0, 8'h00, 3'b111},
    {1'b0, 8'h00, 3'b110}, {1'b0, 8'h00, 3'b111},
    {1'b0, 8'h00, 3'b100}                          // idle again (R4)
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ready_o, busy_o, sdo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sertx_dbuf #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .ready_o(ready_o), .busy_o(busy_o), .sdo_o(sdo_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic r, input logic b, input logic q);
    chk(tag, "ready_o", ready_o, r);
    chk(tag, "busy_o", busy_o, b);
    chk(tag, "sdo_o", sdo_o, q);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset
    chk_all("R1", 1'b1, 1'b0, 1'b0);
    // R10: default width
    chk("R10", "width", ($bits(data_i) == 8), 1'b1);

    // Table walk: R2 stream bits, R4 busy, R5/R6/R8 ready
    for (int i = 0; i < NV; i++) begin
      chk("R8/R5", "ready_o", ready_o, VEC[i][2]);
      chk("R4", "busy_o", busy_o, VEC[i][1]);
      chk("R2/R7/R9", "sdo_o", sdo_o, VEC[i][0]);
      load_i = VEC[i][11];
      data_i = VEC[i][10:3];
      @(negedge clk);
    end
    load_i = 1'b0;

    // Directed: single word 8'h80 from idle
    load_i = 1'b1; data_i = 8'h80;
    @(negedge clk);
    load_i = 1'b0; data_i = '0;
    chk_all("R3", 1'b1, 1'b1, 1'b1);
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      chk_all("R2", 1'b1, 1'b1, 1'b0);
    end
    @(negedge clk);
    chk_all("R4", 1'b1, 1'b0, 1'b0);

    // Directed: reset in the middle of a word with a word queued
    load_i = 1'b1; data_i = 8'hFF;
    @(negedge clk);
    data_i = 8'hFF;
    @(negedge clk);
    load_i = 1'b0;
    chk_all("R6", 1'b0, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk_all("R1", 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule